// File: doc/BRIEF.md
# Low-Transition BIST Pattern Generator

This block produces test vectors for built-in self-test with low switching activity between neighbouring vectors. A small binary step counter feeds a Gray-code converter, and the Gray code is XORed onto the low bits of a seed held in a maximal-length Fibonacci LFSR. The LFSR moves to its next seed only on an enabled cycle in which an all-zero detector on the counter is high. Within one seed, successive vectors therefore differ in a single bit. A new pseudo-random seed starts after each full lap of the counter.

The generator runs from a single clock. Instead of gating the LFSR clock, the zero detector drives a synchronous advance enable. A load strobe writes a start seed and clears the counter. A zero seed is replaced by a fixed nonzero default, so the LFSR cannot lock up. Each enabled cycle yields one registered pattern together with a one-cycle valid pulse.

Top module: `low_transition_tpg`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, `valid_o` is 0 and `pattern_o` is 0. The internal counter restarts at 0 and the seed restarts at `DEF_SEED` (default 8'hE1).
- R2: `valid_o` is 1 in the cycle after an edge at which `en_i`=1 and `load_i`=0, and 0 after every other edge. While `valid_o` is 0, `pattern_o` keeps its previous value.
- R3: The first pattern after reset or after a load equals the current seed, because the counter is 0 and its Gray code is 0.
- R4: Each pattern equals `seed ^ {0, gray(count)}`, where gray(c) = c ^ (c >> 1) over the low M bits. Bits N-1..M equal the seed bits.
- R5: The seed changes only at an enabled, non-load edge where the counter is 0. It then becomes `{seed[N-2:0], ^(seed & TAPS)}`, with TAPS = 8'b1011_1000 for N=8. The counter steps by 1 modulo 2^M on every enabled, non-load edge.
- R6: Two patterns emitted in sequence under the same seed differ in exactly one bit. With M=4, 16 distinct counter states occur before the counter repeats.
- R7: A load edge (`load_i`=1) sets the seed to `seed_i` and clears the counter. If `seed_i` is 0, the seed is set to `DEF_SEED` instead.
- R8: A load edge takes priority over `en_i`. No pattern is emitted for it, the counter does not step, and the LFSR does not advance.
- R9: The seed is never zero. Starting from any loaded seed with N=8 and M=4, pattern number 4080 (counting from 0) equals that seed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Emit one pattern per edge while high |
| load_i | input | 1 | Seed load strobe, takes priority over `en_i` |
| seed_i | input | N | Seed value captured on a load |
| pattern_o | output | N | Registered test vector |
| valid_o | output | 1 | One-cycle pulse per emitted pattern |

## Verification
A wrong counter state appears at once as a pattern whose low bits break the Gray sequence, or as a step of more than one bit within a seed block. A wrong seed or a misplaced advance shows up at the boundary of the next block at the latest, within 2^M enabled cycles. Errors in the tap set show up as a seed that does not return to its start after 2^N-1 advances. The bench therefore runs one full LFSR period.

// File: rtl/lowtran_pkg.sv
package lowtran_pkg;
    localparam int unsigned DEF_N = 8;
    localparam int unsigned DEF_M = 4;
    localparam logic [DEF_N-1:0] DEF_TAPS = 8'b1011_1000;
    localparam logic [DEF_N-1:0] DEF_SEED_VAL = 8'hE1;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOAD = 2'd2
    } step_e;
endpackage

// File: rtl/lt_step_counter.sv
module lt_step_counter
    import lowtran_pkg::*;
#(
    parameter int unsigned M = DEF_M
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  step_e        step_i,
    output logic [M-1:0] cnt_o,
    output logic         zero_o
);
    logic [M-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            case (step_i)
                ST_LOAD: cnt_q <= '0;
                ST_RUN:  cnt_q <= cnt_q + 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = ~|cnt_q;

    // R5: the counter steps by one on a run edge
    a_r5_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
        step_i == ST_RUN |=> cnt_q == M'($past(cnt_q) + 1'b1));
    // R7: a load clears the counter
    a_r7_load_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        step_i == ST_LOAD |=> cnt_q == '0);
endmodule

// File: rtl/lt_seed_lfsr.sv
module lt_seed_lfsr
    import lowtran_pkg::*;
#(
    parameter int unsigned N = DEF_N,
    parameter logic [N-1:0] TAPS = DEF_TAPS,
    parameter logic [N-1:0] DEF_SEED = DEF_SEED_VAL
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  step_e        step_i,
    input  logic         adv_i,
    input  logic [N-1:0] seed_i,
    output logic [N-1:0] seed_o
);
    logic [N-1:0] seed_q;
    logic         fb;

    assign fb = ^(seed_q & TAPS);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seed_q <= DEF_SEED;
        end else if (step_i == ST_LOAD) begin
            seed_q <= (seed_i == '0) ? DEF_SEED : seed_i;
        end else if (step_i == ST_RUN && adv_i) begin
            seed_q <= {seed_q[N-2:0], fb};
        end
    end

    assign seed_o = seed_q;

    // R5: the seed holds unless a run edge sees a zero counter
    a_r5_seed_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i == ST_HOLD) || (step_i == ST_RUN && !adv_i) |=> $stable(seed_q));
    // R7: a zero seed is replaced by the default
    a_r7_zero_subst: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i == ST_LOAD && seed_i == '0) |=> seed_q == DEF_SEED);
    // R9: the seed is never zero
    a_r9_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
        seed_q != '0);
endmodule

// File: rtl/lt_gray_mix.sv
module lt_gray_mix #(
    parameter int unsigned N = 8,
    parameter int unsigned M = 4
) (
    input  logic [N-1:0] seed_i,
    input  logic [M-1:0] cnt_i,
    output logic [N-1:0] mix_o
);
    logic [M-1:0] gray;

    assign gray = cnt_i ^ (cnt_i >> 1);

    generate
        if (N == M) begin : g_full
            assign mix_o = seed_i ^ gray;
        end else begin : g_part
            assign mix_o = {seed_i[N-1:M], seed_i[M-1:0] ^ gray};
        end
    endgenerate
endmodule

// File: rtl/low_transition_tpg.sv
module low_transition_tpg
    import lowtran_pkg::*;
#(
    parameter int unsigned N = DEF_N,
    parameter int unsigned M = DEF_M,
    parameter logic [N-1:0] TAPS = DEF_TAPS,
    parameter logic [N-1:0] DEF_SEED = DEF_SEED_VAL
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic         load_i,
    input  logic [N-1:0] seed_i,
    output logic [N-1:0] pattern_o,
    output logic         valid_o
);
    step_e        step;
    logic [M-1:0] cnt;
    logic         cnt_zero;
    logic [N-1:0] seed;
    logic [N-1:0] mix;
    logic [N-1:0] pat_q;
    logic         vld_q;

    always_comb begin
        if (load_i)    step = ST_LOAD;
        else if (en_i) step = ST_RUN;
        else           step = ST_HOLD;
    end

    lt_step_counter #(.M(M)) u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .step_i(step),
        .cnt_o (cnt),
        .zero_o(cnt_zero)
    );

    lt_seed_lfsr #(.N(N), .TAPS(TAPS), .DEF_SEED(DEF_SEED)) u_lfsr (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .step_i(step),
        .adv_i (cnt_zero),
        .seed_i(seed_i),
        .seed_o(seed)
    );

    lt_gray_mix #(.N(N), .M(M)) u_mix (
        .seed_i(seed),
        .cnt_i (cnt),
        .mix_o (mix)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pat_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= (step == ST_RUN);
            if (step == ST_RUN) pat_q <= mix;
        end
    end

    assign pattern_o = pat_q;
    assign valid_o   = vld_q;

    // R2: an enabled, non-load edge yields a valid pulse
    a_r2_valid_on_run: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !load_i) |=> valid_o);
    // R2 and R8: any other edge gives no pulse and leaves the pattern unchanged
    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !(en_i && !load_i) |=> (!valid_o && $stable(pattern_o)));
    // R6: within one seed, back-to-back patterns differ in one bit
    a_r6_one_bit: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !load_i && valid_o && cnt != M'(1)) |=>
        $countones(pattern_o ^ $past(pattern_o)) == 1);
endmodule

// File: tb/test_low_transition_tpg.sv
module test_low_transition_tpg;
    localparam int N = 8;
    localparam int M = 4;
    localparam logic [N-1:0] TAPS = 8'b1011_1000;
    localparam logic [N-1:0] DEFS = 8'hE1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         load = 1'b0;
    logic [N-1:0] seed_in = '0;
    logic [N-1:0] pattern;
    logic         valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [N-1:0] m_seed, m_pat;
    logic [M-1:0] m_cnt;
    logic         m_vld;
    logic [N-1:0] prev_pat;
    bit           have_prev;
    logic [M-1:0] used_cnt;

    always #4 clk = ~clk;

    low_transition_tpg #(.N(N), .M(M)) i_low_transition_tpg (
        .clk_i(clk), .rst_i(rst), .en_i(en), .load_i(load),
        .seed_i(seed_in), .pattern_o(pattern), .valid_o(valid)
    );

    function automatic logic [N-1:0] f_next(input logic [N-1:0] s);
        return {s[N-2:0], ^(s & TAPS)};
    endfunction

    function automatic logic [N-1:0] f_mix(input logic [N-1:0] s, input logic [M-1:0] c);
        logic [N-1:0] g;
        g = '0;
        g[M-1:0] = c ^ (c >> 1);
        return s ^ g;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock edge with the given inputs; the model is updated and outputs compared
    task automatic cyc(input bit e, input bit l, input logic [N-1:0] s, input string req);
        @(negedge clk);
        en = e; load = l; seed_in = s;
        @(posedge clk);
        if (rst) begin
            m_seed = DEFS; m_cnt = '0; m_vld = 1'b0; m_pat = '0; have_prev = 0;
        end else if (l) begin
            m_seed = (s == '0) ? DEFS : s; m_cnt = '0; m_vld = 1'b0; have_prev = 0;
        end else if (e) begin
            m_pat = f_mix(m_seed, m_cnt); m_vld = 1'b1; used_cnt = m_cnt;
            if (m_cnt == '0) m_seed = f_next(m_seed);
            m_cnt = m_cnt + 1'b1;
        end else begin
            m_vld = 1'b0;
        end
        #2;
        check({req, " valid"}, 32'(valid), 32'(m_vld));
        check({req, " pattern"}, 32'(pattern), 32'(m_pat));
        if (m_vld) begin
            if (have_prev && used_cnt != M'(1))
                check("R6 hamming", 32'($countones(pattern ^ prev_pat)), 32'd1);
            prev_pat = pattern; have_prev = 1;
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        cyc(1, 0, 8'h00, "R1 reset");
        cyc(1, 1, 8'h33, "R1 reset");
        rst = 1'b0;
        // R1: first edge after reset with the enable low
        cyc(0, 0, 8'h00, "R1 idle");
        // R3: the first pattern is the default seed
        cyc(1, 0, 8'h00, "R3");
        check("R3 first pattern", 32'(pattern), 32'(DEFS));
        // R6: one full lap of the counter; R5: the seed steps at the block edge
        for (int i = 0; i < 20; i++) cyc(1, 0, 8'h00, "R5/R6 lap");
        // R2: the enable low holds the pattern
        for (int i = 0; i < 3; i++) cyc(0, 0, 8'h00, "R2 hold");
        // R7: a zero seed load gives the default
        cyc(0, 1, 8'h00, "R7 zero load");
        cyc(1, 0, 8'h00, "R7");
        check("R7 default subst", 32'(pattern), 32'(DEFS));
        // R8: a load together with the enable
        cyc(1, 1, 8'h5A, "R8 load prio");
        check("R8 no valid", 32'(valid), 32'd0);
        cyc(1, 0, 8'h00, "R8");
        check("R8 loaded seed", 32'(pattern), 32'h5A);
        // R9: a full LFSR period returns to the loaded seed
        cyc(0, 1, 8'h3C, "R9 load");
        for (int k = 0; k <= 4080; k++) begin
            cyc(1, 0, 8'h00, "R9 run");
            if (k == 4080) check("R9 period", 32'(pattern), 32'h3C);
            if (k == 16) check("R4 upper bits", 32'(pattern[N-1:M]), 32'(f_next(8'h3C) >> M));
        end
        // random mix of enable, idle and loads
        for (int i = 0; i < 3000; i++) begin
            automatic int r = $urandom_range(0, 99);
            if (r < 2) cyc($urandom_range(0, 1), 1, 8'($urandom), "R7 rand load");
            else if (r < 22) cyc(0, 0, 8'h00, "R2 rand idle");
            else cyc(1, 0, 8'h00, "R4 rand run");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule